// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block sequences program and erase operations on a non-volatile array of 16-bit half-words and guards them with a key-based lock. Software sees five word registers on a simple register bus: a key register, a control register, an address register, a status register and a program-data register. The array is outside the block. The controller addresses it, reads the current content of the target location, and issues one-cycle program and page-erase strobes. Each operation keeps the busy flag high for a parameterised number of cycles.

The array is split into pages of 2^PAGE_W half-words. Pages with index below MAIN_PAGES form the main array. Higher pages form an information block, which erase commands never touch. A mass erase walks the main pages in ascending order and issues one page-erase strobe per page.

Two state machines do the work. The key guard has the states LK_LOCKED, LK_HALF, LK_OPEN and LK_DEAD. A correct first key moves LK_LOCKED to LK_HALF, and a correct second key moves LK_HALF to LK_OPEN. A relock moves LK_OPEN back to LK_LOCKED. Any wrong or stray key moves the guard to LK_DEAD, which is left only by reset. The operation sequencer has the states OP_IDLE, OP_PROG, OP_PAGE and OP_MASS. A launch moves OP_IDLE to the matching busy state. When the counter expires, OP_PROG and OP_PAGE return to OP_IDLE. OP_MASS reloads its counter for the next main page, or returns to OP_IDLE after the last one.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the controller is locked (control register bit 7 reads 1) and control bits 2:0 read 0. The address register reads 0. The status register reads 0.
- R2: Writing KEY_FIRST and then KEY_SECOND to the key register (select 0) unlocks the controller, so control bit 7 reads 0.
- R3: A key value that does not match, or a key written out of order (which includes any key write while unlocked), keeps the controller locked until the next reset, even if the correct pair follows.
- R4: While locked, writes to the control (select 1), address (select 2) or program-data (select 4) register have no effect and set the write-protect error, status bit 4.
- R5: Writing control bit 7 while unlocked relocks the controller and clears control bits 2:0. The key pair then unlocks it again.
- R6: With program-enable (control bit 0) set, writing the program-data register starts a program cycle. Status bit 0 (busy) is then high for PROG_CYCLES cycles. At the end the low 16 bits of the written data are stored at the address register's location, and end-of-operation (status bit 5) is set.
- R7: A program-data write whose target location does not read 16'hFFFF sets the programming error (status bit 2). It starts no busy period and changes nothing in the array.
- R8: A control write with start (bit 6) and page-erase (bit 1), with mass-erase (bit 2) clear, erases the page that contains the address register's location. Busy is high for ERASE_CYCLES cycles, then end-of-operation is set.
- R9: A page-erase start whose page index (address bits ADDR_W-1:PAGE_W) is MAIN_PAGES or above sets the write-protect error. It erases nothing and raises no busy.
- R10: A control write with start and mass-erase (bit 2) erases the main pages 0 to MAIN_PAGES-1 in ascending order, one strobe per page. Busy is high for MAIN_PAGES*ERASE_CYCLES cycles. The information pages are untouched, and end-of-operation is set at the end.
- R11: Writing 1 to status bits 2, 4 or 5 clears them, and writing 0 leaves them as they are. A flag that is set and cleared in the same cycle stays set.
- R12: While busy, writes to the control, address and program-data registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select: 0 key, 1 control, 2 address, 3 status, 4 program data |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| mem_addr | output | ADDR_W | Array half-word address |
| mem_wdata | output | 16 | Half-word to program |
| mem_rdata | input | 16 | Current array content at mem_addr |
| mem_prog | output | 1 | One-cycle program strobe |
| mem_page_erase | output | 1 | One-cycle erase strobe for the page containing mem_addr |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- LK_DEAD never releases.
- The open state is reached only from LK_HALF.
- Blocked control and address writes leave their registers unchanged, and blocked writes always raise the write-protect flag.
- An erase strobe never addresses an information page.
- A mass erase steps its page index by exactly one.
- Completion raises end-of-operation and drops busy together.

The bench scenarios are needed to show the rest: the exact busy lengths, the order and addresses of array strobes against a scoreboard, the stored data, the blank check, the write-1-to-clear behaviour, the relock, and that a frozen lock survives a correct key pair.

// File: rtl/flc_pkg.sv
package flc_pkg;
    // register selects
    localparam logic [2:0] RS_KEY  = 3'd0;
    localparam logic [2:0] RS_CTRL = 3'd1;
    localparam logic [2:0] RS_ADDR = 3'd2;
    localparam logic [2:0] RS_STAT = 3'd3;
    localparam logic [2:0] RS_DATA = 3'd4;

    // control bit positions
    localparam int CB_PROG  = 0;
    localparam int CB_PAGE  = 1;
    localparam int CB_MASS  = 2;
    localparam int CB_START = 6;
    localparam int CB_LOCK  = 7;

    // status bit positions
    localparam int SB_BUSY  = 0;
    localparam int SB_PGERR = 2;
    localparam int SB_WPERR = 4;
    localparam int SB_EOP   = 5;

    localparam logic [15:0] ERASED_HW = 16'hFFFF;

    typedef enum logic [1:0] {LK_LOCKED, LK_HALF, LK_OPEN, LK_DEAD} lock_st_e;
    typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_PAGE, OP_MASS} op_st_e;
endpackage

// File: rtl/flc_key_guard.sv
module flc_key_guard
    import flc_pkg::*;
#(
    parameter logic [31:0] KEY_FIRST  = 32'hA5C3_1E0F,
    parameter logic [31:0] KEY_SECOND = 32'h5A3C_E1F0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_we,
    input  logic [31:0] key_val,
    input  logic        relock,
    output logic        unlocked
);
    lock_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_LOCKED: if (key_we) st_d = (key_val == KEY_FIRST) ? LK_HALF : LK_DEAD;
            LK_HALF:   if (key_we) st_d = (key_val == KEY_SECOND) ? LK_OPEN : LK_DEAD;
            LK_OPEN: begin
                if (key_we)      st_d = LK_DEAD;
                else if (relock) st_d = LK_LOCKED;
            end
            LK_DEAD:   st_d = LK_DEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_LOCKED;
        else        st_q <= st_d;
    end

    always_comb unlocked = (st_q == LK_OPEN);

    // R3: a frozen lock is left only through reset
    p_dead_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_DEAD) |=> (st_q == LK_DEAD));

    // R2: opening is reached only from the half-unlocked state
    p_open_after_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(st_q == LK_HALF));
endmodule

// File: rtl/flc_op_seq.sv
module flc_op_seq
    import flc_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PAGE_W       = 5,
    parameter int MAIN_PAGES   = 28,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_prog,
    input  logic              go_page,
    input  logic              go_mass,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [15:0]       prog_data,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_prog,
    output logic              mem_page_erase
);
    localparam int PG_IDX_W = ADDR_W - PAGE_W;
    localparam int MAXC     = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W    = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0]    PROG_LD   = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0]    ERASE_LD  = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [PG_IDX_W-1:0] LAST_MAIN = PG_IDX_W'(MAIN_PAGES - 1);

    op_st_e                st_q, st_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [PG_IDX_W-1:0]   page_q, page_d;
    logic [ADDR_W-1:0]     tgt_q;
    logic [15:0]           data_q;
    logic                  last;

    always_comb last = (cnt_q == '0);

    // next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        page_d = page_q;
        unique case (st_q)
            OP_IDLE: begin
                if (go_mass) begin
                    st_d = OP_MASS; cnt_d = ERASE_LD; page_d = '0;
                end else if (go_page) begin
                    st_d = OP_PAGE; cnt_d = ERASE_LD;
                end else if (go_prog) begin
                    st_d = OP_PROG; cnt_d = PROG_LD;
                end
            end
            OP_PROG, OP_PAGE: begin
                if (last) st_d = OP_IDLE;
                else      cnt_d = cnt_q - 1'b1;
            end
            OP_MASS: begin
                if (!last) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (page_q == LAST_MAIN) begin
                    st_d = OP_IDLE;
                end else begin
                    page_d = page_q + 1'b1;
                    cnt_d  = ERASE_LD;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= OP_IDLE;
            cnt_q  <= '0;
            page_q <= '0;
            tgt_q  <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            page_q <= page_d;
            if (st_q == OP_IDLE && (go_prog || go_page)) tgt_q <= tgt_addr;
            if (st_q == OP_IDLE && go_prog)              data_q <= prog_data;
        end
    end

    // outputs
    always_comb begin
        busy           = 1'b0;
        done           = 1'b0;
        mem_prog       = 1'b0;
        mem_page_erase = 1'b0;
        mem_addr       = tgt_addr;
        mem_wdata      = data_q;
        unique case (st_q)
            OP_IDLE: mem_addr = tgt_addr;
            OP_PROG: begin
                busy = 1'b1; mem_addr = tgt_q;
                mem_prog = last; done = last;
            end
            OP_PAGE: begin
                busy = 1'b1; mem_addr = tgt_q;
                mem_page_erase = last; done = last;
            end
            OP_MASS: begin
                busy = 1'b1; mem_addr = {page_q, {PAGE_W{1'b0}}};
                mem_page_erase = last; done = last && (page_q == LAST_MAIN);
            end
        endcase
    end

    // R9, R10: no erase strobe ever reaches an information page
    p_info_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_page_erase |-> (mem_addr[ADDR_W-1:PAGE_W] <= LAST_MAIN));

    // R10: mass erase advances one page at a time
    p_mass_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OP_MASS && last && page_q != LAST_MAIN) |=> (page_q == $past(page_q) + 1'b1));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flc_pkg::*;
#(
    parameter int          ADDR_W       = 10,
    parameter int          PAGE_W       = 5,
    parameter int          MAIN_PAGES   = 28,
    parameter int          PROG_CYCLES  = 6,
    parameter int          ERASE_CYCLES = 20,
    parameter logic [31:0] KEY_FIRST    = 32'hA5C3_1E0F,
    parameter logic [31:0] KEY_SECOND   = 32'h5A3C_E1F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              mem_prog,
    output logic              mem_page_erase
);
    localparam int PG_IDX_W = ADDR_W - PAGE_W;
    localparam logic [PG_IDX_W-1:0] LAST_MAIN = PG_IDX_W'(MAIN_PAGES - 1);

    logic wr_key, wr_ctrl, wr_addr, wr_stat, wr_data, gated;
    logic unlocked, op_busy, op_done, ok_cfg;
    logic relock, start_req, page_req, prog_req, info_hit, blank;
    logic go_prog, go_page, go_mass, set_pgerr, set_wperr;
    logic [2:0]        ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              pgerr_q, wperr_q, eop_q;

    always_comb begin
        wr_key  = reg_we && (reg_sel == RS_KEY);
        wr_ctrl = reg_we && (reg_sel == RS_CTRL);
        wr_addr = reg_we && (reg_sel == RS_ADDR);
        wr_stat = reg_we && (reg_sel == RS_STAT);
        wr_data = reg_we && (reg_sel == RS_DATA);
        gated   = wr_ctrl || wr_addr || wr_data;
        ok_cfg  = unlocked && !op_busy;

        relock    = wr_ctrl && ok_cfg && reg_wdata[CB_LOCK];
        start_req = wr_ctrl && ok_cfg && !reg_wdata[CB_LOCK] && reg_wdata[CB_START];
        go_mass   = start_req && reg_wdata[CB_MASS];
        page_req  = start_req && !reg_wdata[CB_MASS] && reg_wdata[CB_PAGE];
        info_hit  = addr_q[ADDR_W-1:PAGE_W] > LAST_MAIN;
        go_page   = page_req && !info_hit;
        prog_req  = wr_data && ok_cfg && ctrl_q[CB_PROG];
        blank     = (mem_rdata == ERASED_HW);
        go_prog   = prog_req && blank;
        set_pgerr = prog_req && !blank;
        set_wperr = (gated && !unlocked) || (page_req && info_hit);
    end

    flc_key_guard #(
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_we  (wr_key),
        .key_val (reg_wdata),
        .relock  (relock),
        .unlocked(unlocked)
    );

    flc_op_seq #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .MAIN_PAGES  (MAIN_PAGES),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_prog       (go_prog),
        .go_page       (go_page),
        .go_mass       (go_mass),
        .tgt_addr      (addr_q),
        .prog_data     (reg_wdata[15:0]),
        .busy          (op_busy),
        .done          (op_done),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_prog      (mem_prog),
        .mem_page_erase(mem_page_erase)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            addr_q  <= '0;
            pgerr_q <= 1'b0;
            wperr_q <= 1'b0;
            eop_q   <= 1'b0;
        end else begin
            if (relock)                   ctrl_q <= '0;
            else if (wr_ctrl && ok_cfg)   ctrl_q <= reg_wdata[2:0];
            if (wr_addr && ok_cfg)        addr_q <= reg_wdata[ADDR_W-1:0];
            pgerr_q <= set_pgerr | (pgerr_q & ~(wr_stat & reg_wdata[SB_PGERR]));
            wperr_q <= set_wperr | (wperr_q & ~(wr_stat & reg_wdata[SB_WPERR]));
            eop_q   <= op_done   | (eop_q   & ~(wr_stat & reg_wdata[SB_EOP]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            RS_CTRL: begin
                reg_rdata[CB_LOCK] = !unlocked;
                reg_rdata[2:0]     = ctrl_q;
            end
            RS_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
            RS_STAT: begin
                reg_rdata[SB_BUSY]  = op_busy;
                reg_rdata[SB_PGERR] = pgerr_q;
                reg_rdata[SB_WPERR] = wperr_q;
                reg_rdata[SB_EOP]   = eop_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R4: a blocked control write leaves the control bits alone
    p_locked_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !unlocked) |=> $stable(ctrl_q));

    // R4: every blocked write is flagged
    p_locked_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && !unlocked) |=> wperr_q);

    // R12: the address register is frozen while busy
    p_busy_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && wr_addr) |=> $stable(addr_q));

    // R6, R8, R10: completion raises end-of-operation as busy falls
    p_done_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (eop_q && !op_busy));

    // R7: a rejected program never starts a busy period
    p_pgerr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_pgerr |=> (pgerr_q && !op_busy));
endmodule

// File: tb/tb_flash_pe_ctrl.sv
module tb_flash_pe_ctrl;
    localparam int CLK_PERIOD   = 10;
    localparam int ADDR_W       = 10;
    localparam int PAGE_W       = 5;
    localparam int MAIN_PAGES   = 28;
    localparam int PROG_CYCLES  = 6;
    localparam int ERASE_CYCLES = 20;
    localparam logic [31:0] KEY_FIRST  = 32'hA5C3_1E0F;
    localparam logic [31:0] KEY_SECOND = 32'h5A3C_E1F0;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [2:0] S_KEY = 3'd0, S_CTRL = 3'd1, S_ADDR = 3'd2, S_STAT = 3'd3, S_DATA = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        reg_sel = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_wdata, mem_rdata;
    logic              mem_prog, mem_page_erase;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        int    kind;   // 1 program, 2 page erase
        int    loc;    // half-word address or page index
        string req;
    } rec_t;
    rec_t exp_q[$];

    logic [15:0] mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pe_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_prog(mem_prog),
        .mem_page_erase(mem_page_erase)
    );

    // behavioural array
    assign mem_rdata = mem[mem_addr];
    initial for (int i = 0; i < DEPTH; i++) mem[i] = 16'(i) ^ 16'h5A5A;
    always @(posedge clk) begin
        if (mem_prog) mem[mem_addr] <= mem_wdata;
        if (mem_page_erase)
            for (int k = 0; k < (1 << PAGE_W); k++)
                mem[{mem_addr[ADDR_W-1:PAGE_W], k[PAGE_W-1:0]}] <= 16'hFFFF;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares each array strobe with the next expected item
    always @(negedge clk) begin
        if (rst_n && (mem_prog || mem_page_erase)) begin
            int kind;
            int loc;
            kind = mem_prog ? 1 : 2;
            loc  = mem_prog ? int'(mem_addr) : int'(mem_addr[ADDR_W-1:PAGE_W]);
            if (exp_q.size() == 0) begin
                check("R10 unexpected strobe", {16'(kind), 16'(loc)}, 32'h0);
            end else begin
                rec_t r;
                r = exp_q.pop_front();
                check(r.req, {16'(kind), 16'(loc)}, {16'(r.kind), 16'(r.loc)});
            end
        end
    end

    task automatic push_exp(input int kind, input int loc, input string req);
        rec_t r;
        r.kind = kind; r.loc = loc; r.req = req;
        exp_q.push_back(r);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        rd(S_STAT, v);
        while (v[0] && n < 5000) begin
            n++;
            @(negedge clk);
            rd(S_STAT, v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic unlock();
        wr(S_KEY, KEY_FIRST);
        wr(S_KEY, KEY_SECOND);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        do_reset();

        // R1 reset state
        rd(S_CTRL, v); check("R1 ctrl", v, 32'h80);
        rd(S_STAT, v); check("R1 stat", v, 32'h0);
        rd(S_ADDR, v); check("R1 addr", v, 32'h0);

        // R4 locked writes
        wr(S_CTRL, 32'h01);
        rd(S_CTRL, v); check("R4 ctrl unchanged", v, 32'h80);
        rd(S_STAT, v); check("R4 wperr", v, 32'h10);
        wr(S_ADDR, 32'd5);
        rd(S_ADDR, v); check("R4 addr unchanged", v, 32'h0);

        // R11 write-one-to-clear
        wr(S_STAT, 32'h0);
        rd(S_STAT, v); check("R11 zero write keeps", v, 32'h10);
        wr(S_STAT, 32'h10);
        rd(S_STAT, v); check("R11 one write clears", v, 32'h0);

        // R2 unlock
        unlock();
        rd(S_CTRL, v); check("R2 unlocked", v, 32'h00);

        // R8 page erase of page 3
        wr(S_CTRL, 32'h02);
        wr(S_ADDR, 32'd101);
        push_exp(2, 3, "R8 erase strobe");
        wr(S_CTRL, 32'h42);
        wait_idle(n); check("R8 busy length", n, ERASE_CYCLES);
        rd(S_STAT, v); check("R8 eop", v, 32'h20);
        check("R8 page first", mem[96], 16'hFFFF);
        check("R8 page last", mem[127], 16'hFFFF);
        check("R8 next page kept", mem[128], 16'(128) ^ 16'h5A5A);
        wr(S_STAT, 32'h20);

        // R6 program
        wr(S_CTRL, 32'h01);
        wr(S_ADDR, 32'd100);
        push_exp(1, 100, "R6 program strobe");
        wr(S_DATA, 32'h0000_BEEF);
        wait_idle(n); check("R6 busy length", n, PROG_CYCLES);
        rd(S_STAT, v); check("R6 eop", v, 32'h20);
        check("R6 stored", mem[100], 16'hBEEF);
        wr(S_STAT, 32'h20);

        // R12 address write during busy ignored
        wr(S_ADDR, 32'd101);
        push_exp(1, 101, "R12 program strobe");
        wr(S_DATA, 32'h0000_1357);
        wr(S_ADDR, 32'd7);
        wait_idle(n);
        rd(S_ADDR, v); check("R12 addr held", v, 32'd101);
        check("R12 stored", mem[101], 16'h1357);
        wr(S_STAT, 32'h20);

        // R7 program onto non-erased location
        wr(S_ADDR, 32'd100);
        wr(S_DATA, 32'h0000_0000);
        rd(S_STAT, v); check("R7 pgerr no busy", v, 32'h04);
        repeat (PROG_CYCLES + 2) @(negedge clk);
        check("R7 array kept", mem[100], 16'hBEEF);
        wr(S_STAT, 32'h04);

        // R9 page erase aimed at information page
        wr(S_CTRL, 32'h02);
        wr(S_ADDR, 32'd960);
        wr(S_CTRL, 32'h42);
        rd(S_STAT, v); check("R9 wperr no busy", v, 32'h10);
        repeat (ERASE_CYCLES + 2) @(negedge clk);
        check("R9 info kept", mem[960], 16'(960) ^ 16'h5A5A);
        wr(S_STAT, 32'h10);

        // R10 mass erase
        for (int p = 0; p < MAIN_PAGES; p++) push_exp(2, p, "R10 mass strobe");
        wr(S_CTRL, 32'h44);
        wait_idle(n); check("R10 busy length", n, MAIN_PAGES * ERASE_CYCLES);
        rd(S_STAT, v); check("R10 eop", v, 32'h20);
        check("R10 first main", mem[0], 16'hFFFF);
        check("R10 last main", mem[MAIN_PAGES * 32 - 1], 16'hFFFF);
        check("R10 info kept", mem[MAIN_PAGES * 32], 16'(MAIN_PAGES * 32) ^ 16'h5A5A);
        check("R10 all strobes seen", exp_q.size(), 0);
        wr(S_STAT, 32'h20);

        // R5 relock then unlock again
        wr(S_CTRL, 32'h81);
        rd(S_CTRL, v); check("R5 relocked", v, 32'h80);
        wr(S_CTRL, 32'h01);
        rd(S_STAT, v); check("R5 locked write flagged", v, 32'h10);
        wr(S_STAT, 32'h10);
        unlock();
        rd(S_CTRL, v); check("R5 unlocked again", v, 32'h00);

        // R3 wrong key freezes the lock
        wr(S_CTRL, 32'h80);
        wr(S_KEY, 32'h0000_0001);
        unlock();
        rd(S_CTRL, v); check("R3 wrong key stays locked", v, 32'h80);

        // R3 out-of-order keys
        do_reset();
        wr(S_KEY, KEY_SECOND);
        unlock();
        rd(S_CTRL, v); check("R3 out of order stays locked", v, 32'h80);

        // R2 reset clears the frozen state
        do_reset();
        unlock();
        rd(S_CTRL, v); check("R2 unlock after reset", v, 32'h00);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule